// File: doc/BRIEF.md
# PHY Management Register Model

This block stands in for the register file of an Ethernet PHY. Software reaches that file through one 32-bit management frame register. A bus write to the frame register starts an access, and the access is carried out on the clock edge that takes the write. The frame names a read or a write, a 10-bit register address and 16 bits of data. The address is split into a PHY number and a register index.

The model holds five registers: control, status, advertisement, interrupt source and interrupt mask. It follows a link-up input through a synchronizer. On each link transition it updates the link bits in status and latches cause bits into the interrupt-source register. That register clears when it is read. Each finished access sets a completion event, which software clears by writing a one to it.

Top module: `mdio_mgmt_model`

## Requirements
- R1: After reset the frame register reads 0 and the completion event is 0. Control reads 0x3000, status 0x7809, advertisement 0x01e1, and interrupt source and interrupt mask read 0.
- R2: Frame bit 29 selects the operation (1 = read, 0 = write). Bits 15:0 carry the data and bits 27:18 carry the register address. The address splits into PHY number = address[9:5] and register index = address[4:0]. When the PHY number is not the configured one (parameter, default 1), a read returns 0 and a write changes nothing.
- R3: A write to index 0 stores the value ANDed with 0x7980. If bit 12 of the written value is 1, status bit 0x0020 is set in the same edge.
- R4: A write to index 4 stores (value & 0x2d7f) | 0x0080. A write to index 30 stores the low 8 bits of the value.
- R5: A read of index 29 returns the latched cause bits and clears them. A second read with no link change in between returns 0.
- R6: When the link input falls, status bits 0x0024 clear and interrupt-source bit 4 sets. When it rises, status bits 0x0024 set and interrupt-source bits 7 and 6 set. With the default two synchronizer stages, the update lands on the third clock edge after the input changes.
- R7: After a read, frame bits 15:0 hold the read data and frame bits 31:16 keep the written value. After a write, the frame register holds the written word unchanged.
- R8: Every frame write sets the completion event, including a write addressed to a foreign PHY number. A cycle with evt_w1c = 1 clears the event. If a frame write arrives in the same cycle, the set wins.
- R9: Reads of indices 5, 6 and every index other than 0, 1, 4, 29 and 30 return 0. Writes to status and to those other indices have no effect.
- R10: With no frame write, the frame register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_wr_en | input | 1 | Bus write strobe for the frame register |
| frm_wr_data | input | 32 | Frame word being written |
| evt_w1c | input | 1 | Write-one-to-clear strobe for the completion event |
| link_up | input | 1 | Link state from the line side, asynchronous |
| frm_rd_data | output | 32 | Current frame register contents |
| mii_done | output | 1 | Completion event bit |

## Verification
Frame accesses and the completion event take effect on the single edge that accepts the strobe. The bench drives each strobe on a falling edge and compares frm_rd_data and mii_done on the next falling edge. Link changes pass through two synchronizer stages and an edge register, so they land three rising edges after the input moves. The bench holds off for four full cycles before it reads status or the cause register back through frames. A bench-side register model gives the expected value of every frame readback.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   localparam int DATA_W = 16;
   localparam int IDX_W  = 5;
   localparam int PHY_W  = 5;
   localparam int CSE_W  = 8;

   localparam logic [DATA_W-1:0] CTL_RST    = 16'h3000;
   localparam logic [DATA_W-1:0] STS_RST    = 16'h7809;
   localparam logic [DATA_W-1:0] ADV_RST    = 16'h01e1;
   localparam logic [DATA_W-1:0] CTL_KEEP   = 16'h7980;
   localparam logic [DATA_W-1:0] ADV_KEEP   = 16'h2d7f;
   localparam logic [DATA_W-1:0] ADV_FORCE  = 16'h0080;
   localparam logic [DATA_W-1:0] STS_ANDONE = 16'h0020;
   localparam logic [DATA_W-1:0] STS_LINK   = 16'h0024;
   localparam logic [CSE_W-1:0]  CSE_DOWN   = 8'h10;
   localparam logic [CSE_W-1:0]  CSE_UP     = 8'hc0;
   localparam int                CTL_AN_BIT = 12;

   typedef enum logic [IDX_W-1:0] {
      IX_CTRL = 5'd0,
      IX_STAT = 5'd1,
      IX_ADV  = 5'd4,
      IX_CSE  = 5'd29,
      IX_MSK  = 5'd30
   } phy_idx_e;

   typedef struct packed {
      logic              is_read;
      logic [PHY_W-1:0]  phy;
      logic [IDX_W-1:0]  idx;
      logic [DATA_W-1:0] data;
   } mgmt_req_t;
endpackage

// File: rtl/mdio_frame_decode.sv
module mdio_frame_decode
   import mdio_mgmt_pkg::*;
#(
   parameter int FRAME_W  = 32,
   parameter int OP_POS   = 29,
   parameter int ADDR_LSB = 18,
   parameter int PHY_NUM  = 1
) (
   input  logic [FRAME_W-1:0] frame_in,
   output mgmt_req_t          req,
   output logic               phy_match
);
   localparam logic [PHY_W-1:0] OWN_PHY = PHY_W'(PHY_NUM);

   always_comb begin
      req.is_read = frame_in[OP_POS];
      req.phy     = frame_in[ADDR_LSB+IDX_W +: PHY_W];
      req.idx     = frame_in[ADDR_LSB +: IDX_W];
      req.data    = frame_in[DATA_W-1:0];
      phy_match   = (req.phy == OWN_PHY);
   end
endmodule

// File: rtl/mdio_link_tracker.sv
module mdio_link_tracker #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_in,
   output logic link_state,
   output logic link_rise,
   output logic link_fall
);
   logic sampled;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sampled = link_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= link_in;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign sampled = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) link_state <= 1'b0;
      else        link_state <= sampled;
   end

   assign link_rise = sampled & ~link_state;
   assign link_fall = ~sampled & link_state;
endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
   import mdio_mgmt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic              rd_go,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              link_rise,
   input  logic              link_fall,
   output logic [DATA_W-1:0] rd_val,
   output logic [DATA_W-1:0] status_q,
   output logic [CSE_W-1:0]  cause_q
);
   logic [DATA_W-1:0] ctl_q, adv_q, sts_d;
   logic [CSE_W-1:0]  msk_q, cse_d;

   always_comb begin
      unique case (idx)
         IX_CTRL: rd_val = ctl_q;
         IX_STAT: rd_val = status_q;
         IX_ADV:  rd_val = adv_q;
         IX_CSE:  rd_val = DATA_W'(cause_q);
         IX_MSK:  rd_val = DATA_W'(msk_q);
         default: rd_val = '0;
      endcase
   end

   always_comb begin
      sts_d = status_q;
      if (wr_go && idx == IX_CTRL && wdata[CTL_AN_BIT]) sts_d = sts_d | STS_ANDONE;
      if (link_fall) sts_d = sts_d & ~STS_LINK;
      if (link_rise) sts_d = sts_d | STS_LINK;
      cse_d = (rd_go && idx == IX_CSE) ? '0 : cause_q;
      if (link_fall) cse_d = cse_d | CSE_DOWN;
      if (link_rise) cse_d = cse_d | CSE_UP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= CTL_RST;
         status_q <= STS_RST;
         adv_q    <= ADV_RST;
         msk_q    <= '0;
         cause_q  <= '0;
      end else begin
         status_q <= sts_d;
         cause_q  <= cse_d;
         if (wr_go) begin
            unique case (idx)
               IX_CTRL: ctl_q <= wdata & CTL_KEEP;
               IX_ADV:  adv_q <= (wdata & ADV_KEEP) | ADV_FORCE;
               IX_MSK:  msk_q <= wdata[CSE_W-1:0];
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/mdio_mgmt_model.sv
module mdio_mgmt_model
   import mdio_mgmt_pkg::*;
#(
   parameter int FRAME_W    = 32,
   parameter int OP_POS     = 29,
   parameter int ADDR_LSB   = 18,
   parameter int PHY_NUM    = 1,
   parameter int LINK_SYNC  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frm_wr_en,
   input  logic [FRAME_W-1:0] frm_wr_data,
   input  logic               evt_w1c,
   input  logic               link_up,
   output logic [FRAME_W-1:0] frm_rd_data,
   output logic               mii_done
);
   localparam int ADDR_TOP = ADDR_LSB + IDX_W + PHY_W;

   generate
      if (ADDR_LSB < DATA_W || ADDR_TOP > FRAME_W) begin : g_bad_addr
         $error("address field must sit above the data field and inside the frame");
      end
      if (OP_POS >= FRAME_W || OP_POS < DATA_W || (OP_POS >= ADDR_LSB && OP_POS < ADDR_TOP)) begin : g_bad_op
         $error("operation bit overlaps another field or lies outside the frame");
      end
      if (PHY_NUM < 0 || PHY_NUM >= (1 << PHY_W)) begin : g_bad_phy
         $error("PHY_NUM does not fit the PHY number field");
      end
      if (LINK_SYNC < 0) begin : g_bad_sync
         $error("LINK_SYNC must not be negative");
      end
   endgenerate

   mgmt_req_t         req;
   logic              phy_match, wr_go, rd_go;
   logic              link_state, link_rise, link_fall;
   logic [DATA_W-1:0] rd_val, phy_status, rd_word;
   logic [CSE_W-1:0]  cause_q;
   logic [FRAME_W-1:0] frame_q;
   logic              done_q;

   mdio_frame_decode #(
      .FRAME_W(FRAME_W), .OP_POS(OP_POS), .ADDR_LSB(ADDR_LSB), .PHY_NUM(PHY_NUM)
   ) u_dec (
      .frame_in(frm_wr_data), .req(req), .phy_match(phy_match)
   );

   mdio_link_tracker #(.SYNC_STAGES(LINK_SYNC)) u_link (
      .clk(clk), .rst_n(rst_n), .link_in(link_up),
      .link_state(link_state), .link_rise(link_rise), .link_fall(link_fall)
   );

   assign wr_go   = frm_wr_en & ~req.is_read & phy_match;
   assign rd_go   = frm_wr_en &  req.is_read & phy_match;

   mdio_phy_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_go(rd_go),
      .idx(req.idx), .wdata(req.data),
      .link_rise(link_rise), .link_fall(link_fall),
      .rd_val(rd_val), .status_q(phy_status), .cause_q(cause_q)
   );

   assign rd_word = phy_match ? rd_val : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         done_q  <= 1'b0;
      end else begin
         if (frm_wr_en)
            frame_q <= req.is_read ? {frm_wr_data[FRAME_W-1:DATA_W], rd_word} : frm_wr_data;
         if (frm_wr_en)    done_q <= 1'b1;
         else if (evt_w1c) done_q <= 1'b0;
      end
   end

   assign frm_rd_data = frame_q;
   assign mii_done    = done_q;
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
   parameter int FRAME_W  = 32,
   parameter int OP_POS   = 29,
   parameter int ADDR_LSB = 18,
   parameter int PHY_NUM  = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frm_wr_en,
   input logic [FRAME_W-1:0] frm_wr_data,
   input logic               evt_w1c,
   input logic [FRAME_W-1:0] frm_rd_data,
   input logic               mii_done,
   input logic               link_state,
   input logic [15:0]        phy_status,
   input logic [7:0]         cause_q
);
   logic foreign_rd, cause_rd;
   assign foreign_rd = frm_wr_en && frm_wr_data[OP_POS] &&
                       (frm_wr_data[ADDR_LSB+5 +: 5] != 5'(PHY_NUM));
   assign cause_rd   = frm_wr_en && frm_wr_data[OP_POS] &&
                       (frm_wr_data[ADDR_LSB+5 +: 5] == 5'(PHY_NUM)) &&
                       (frm_wr_data[ADDR_LSB +: 5] == 5'd29);

   assert_foreign_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      foreign_rd |=> frm_rd_data[15:0] == 16'h0000);

   assert_cause_read_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cause_rd |=> frm_rd_data[15:0] == {8'h00, $past(cause_q)});

   assert_link_up_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_state) |-> ((phy_status & 16'h0024) == 16'h0024) && (cause_q[7:6] == 2'b11));

   assert_link_down_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_state) |-> ((phy_status & 16'h0024) == 16'h0000) && cause_q[4]);

   assert_write_frame_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_wr_en && !frm_wr_data[OP_POS]) |=> frm_rd_data == $past(frm_wr_data));

   assert_read_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_wr_en && frm_wr_data[OP_POS]) |=> frm_rd_data[FRAME_W-1:16] == $past(frm_wr_data[FRAME_W-1:16]));

   assert_done_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frm_wr_en |=> mii_done);

   assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!frm_wr_en && !evt_w1c) |=> $stable(mii_done));

   assert_frame_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_wr_en |=> $stable(frm_rd_data));
endmodule

bind mdio_mgmt_model mdio_mgmt_checker #(
   .FRAME_W(FRAME_W), .OP_POS(OP_POS), .ADDR_LSB(ADDR_LSB), .PHY_NUM(PHY_NUM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frm_wr_en(frm_wr_en), .frm_wr_data(frm_wr_data),
   .evt_w1c(evt_w1c), .frm_rd_data(frm_rd_data), .mii_done(mii_done),
   .link_state(link_state), .phy_status(phy_status), .cause_q(cause_q)
);

// File: tb/mdio_mgmt_model_bench.sv
module mdio_mgmt_model_bench;
   localparam logic [4:0] OWN = 5'd1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_wr_en = 1'b0;
   logic [31:0] frm_wr_data = '0;
   logic        evt_w1c = 1'b0;
   logic        link_up = 1'b0;
   logic [31:0] frm_rd_data;
   logic        mii_done;

   int nvec = 0;
   int nbad = 0;
   bit finished = 1'b0;

   logic [15:0] m_ctl = 16'h3000, m_sts = 16'h7809, m_adv = 16'h01e1;
   logic [7:0]  m_cse = 8'h00, m_msk = 8'h00;
   logic        m_link = 1'b0;

   always #10 clk = ~clk;

   mdio_mgmt_model u_mdio_mgmt_model (
      .clk(clk), .rst_n(rst_n), .frm_wr_en(frm_wr_en), .frm_wr_data(frm_wr_data),
      .evt_w1c(evt_w1c), .link_up(link_up), .frm_rd_data(frm_rd_data), .mii_done(mii_done)
   );

   function automatic logic [31:0] mk_frame(bit rd, logic [4:0] phy, logic [4:0] idx,
                                            logic [15:0] d, logic [31:0] junk);
      return (junk & 32'hD003_0000) | (32'(rd) << 29) | (32'({phy, idx}) << 18) | 32'(d);
   endfunction

   function automatic logic [15:0] model_read(logic [4:0] idx);
      case (idx)
         5'd0:    return m_ctl;
         5'd1:    return m_sts;
         5'd4:    return m_adv;
         5'd29:   return {8'h00, m_cse};
         5'd30:   return {8'h00, m_msk};
         default: return 16'h0000;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_op(bit rd, logic [4:0] phy, logic [4:0] idx, logic [15:0] d,
                        logic [31:0] junk, string req);
      logic [31:0] w, exp;
      logic [15:0] v;
      w = mk_frame(rd, phy, idx, d, junk);
      if (rd) begin
         v = (phy == OWN) ? model_read(idx) : 16'h0000;
         if (phy == OWN && idx == 5'd29) m_cse = 8'h00;
         exp = {w[31:16], v};
      end else begin
         exp = w;
         if (phy == OWN) begin
            case (idx)
               5'd0: begin
                  m_ctl = d & 16'h7980;
                  if (d[12]) m_sts = m_sts | 16'h0020;
               end
               5'd4:  m_adv = (d & 16'h2d7f) | 16'h0080;
               5'd30: m_msk = d[7:0];
               default: ;
            endcase
         end
      end
      @(negedge clk);
      frm_wr_en = 1'b1;
      frm_wr_data = w;
      @(negedge clk);
      frm_wr_en = 1'b0;
      check(req, frm_rd_data, exp);
      check("R8", 32'(mii_done), 32'd1);
   endtask

   task automatic set_link(logic v);
      @(negedge clk);
      link_up = v;
      repeat (4) @(negedge clk);
      if (v != m_link) begin
         if (v) begin m_sts = m_sts | 16'h0024; m_cse = m_cse | 8'hc0; end
         else   begin m_sts = m_sts & ~16'h0024; m_cse = m_cse | 8'h10; end
         m_link = v;
      end
   endtask

   task automatic clear_done();
      @(negedge clk);
      evt_w1c = 1'b1;
      @(negedge clk);
      evt_w1c = 1'b0;
      check("R8", 32'(mii_done), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nvec++;
         nbad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      logic [4:0] idx_pool [10];
      int unsigned seed;
      seed = $urandom(32'd2024);
      idx_pool = '{5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd29, 5'd30, 5'd2, 5'd3, 5'd31};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", frm_rd_data, 32'h0);
      check("R1", 32'(mii_done), 32'd0);
      do_op(1, OWN, 5'd0,  16'h0, 32'h0, "R1");
      do_op(1, OWN, 5'd1,  16'h0, 32'h0, "R1");
      do_op(1, OWN, 5'd4,  16'h0, 32'h0, "R1");
      do_op(1, OWN, 5'd29, 16'h0, 32'h0, "R1");
      do_op(1, OWN, 5'd30, 16'h0, 32'h0, "R1");
      clear_done();

      do_op(0, OWN, 5'd0, 16'hffff, 32'h0, "R3");
      do_op(1, OWN, 5'd0, 16'h0, 32'hffff_ffff, "R3");
      do_op(1, OWN, 5'd1, 16'h0, 32'h0, "R3");

      do_op(0, OWN, 5'd4, 16'h0000, 32'h0, "R4");
      do_op(1, OWN, 5'd4, 16'h0, 32'h0, "R4");
      do_op(0, OWN, 5'd4, 16'hffff, 32'h0, "R4");
      do_op(1, OWN, 5'd4, 16'h0, 32'h0, "R4");
      do_op(0, OWN, 5'd30, 16'habcd, 32'h0, "R4");
      do_op(1, OWN, 5'd30, 16'h0, 32'h0, "R4");

      do_op(0, OWN, 5'd1, 16'h0000, 32'h0, "R9");
      do_op(1, OWN, 5'd1, 16'h0, 32'h0, "R9");
      do_op(1, OWN, 5'd5, 16'h0, 32'h0, "R9");
      do_op(1, OWN, 5'd6, 16'h0, 32'h0, "R9");
      do_op(1, OWN, 5'd31, 16'h0, 32'h0, "R9");

      clear_done();
      do_op(0, 5'd0, 5'd0, 16'h0000, 32'h0, "R2");
      do_op(1, 5'd0, 5'd0, 16'h0, 32'h0, "R2");
      do_op(1, OWN, 5'd0, 16'h0, 32'h0, "R2");

      set_link(1'b1);
      do_op(1, OWN, 5'd1, 16'h0, 32'h0, "R6");
      do_op(1, OWN, 5'd29, 16'h0, 32'h0, "R6");
      do_op(1, OWN, 5'd29, 16'h0, 32'h0, "R5");
      set_link(1'b0);
      do_op(1, OWN, 5'd1, 16'h0, 32'h0, "R6");
      do_op(1, OWN, 5'd29, 16'h0, 32'h0, "R5");
      do_op(1, OWN, 5'd29, 16'h0, 32'h0, "R5");

      // R8: set wins over a simultaneous clear
      @(negedge clk);
      frm_wr_en = 1'b1;
      evt_w1c = 1'b1;
      frm_wr_data = mk_frame(0, OWN, 5'd7, 16'h1234, 32'h0);
      @(negedge clk);
      frm_wr_en = 1'b0;
      evt_w1c = 1'b0;
      check("R8", 32'(mii_done), 32'd1);

      // R10: frame holds without a write
      repeat (3) @(negedge clk);
      check("R10", frm_rd_data, mk_frame(0, OWN, 5'd7, 16'h1234, 32'h0));

      for (int n = 0; n < 400; n++) begin
         int unsigned r;
         logic [4:0] phy, idx;
         r = $urandom;
         phy = (r[3:0] == 4'd0) ? 5'($urandom) : OWN;
         idx = (r[7:4] == 4'd0) ? 5'($urandom) : idx_pool[$urandom % 10];
         if (r[12:8] == 5'd0) set_link(~m_link);
         if (r[15:13] == 3'd0) clear_done();
         do_op(r[16], phy, idx, 16'($urandom), $urandom, r[16] ? "R7" : "R2");
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule